// File: doc/BRIEF.md
# Divided Countdown Interval Timer

This block is a 32-bit down-counter that raises an interrupt request when its count runs out. Software programs three settings: a starting count, a divide setting that slows the count by a power of two, and a timer entry. The timer entry holds an interrupt vector, a mask flag and a mode flag that selects one-shot or periodic operation. A write of the starting count restarts the countdown at once. When the countdown expires, the block puts out a one-cycle request that carries the entry's vector. The request is edge-type, so nothing has to be acknowledged. The present count, and each of the three settings, can be read back through a select input.

In one-shot mode the count runs down to zero, stays there, and raises a single request at the moment it reaches zero. In periodic mode the count runs down to zero and, one tick later, reloads the starting value and raises a request. Each period is therefore the starting count plus one ticks long. The mask flag stops requests but does not stop the counting.

Top module: `interval_timer`

## Requirements
- R1: A write to the divide setting (select code 1) keeps only bits 3, 1 and 0 of the data, and bit 2 always reads back as 0.
- R2: The divide code is formed as {bit 3, bit 1, bit 0} of the divide setting. The shift is (code + 1) mod 8. The count drops by one on every 2^shift-th clock after the last restart, so code 7 divides by one and code 0 divides by two.
- R3: A write to the timer entry (select code 2) stores bit 17 as the periodic flag, bit 16 as the mask flag and bits 7:0 as the vector, and reads back with only those bits set.
- R4: A write to the starting count (select code 0) loads that value into the count on the same edge and restarts the divide phase. With select code 3, the read port shows the present count.
- R5: In one-shot mode a request is raised on the edge where the count steps from 1 to 0. The count then stays at 0 and no further request follows. A starting count of 0 raises no request.
- R6: In periodic mode, a tick that finds the count at 0 reloads the starting value and raises a request, so requests are (starting count + 1) ticks apart.
- R7: While the mask flag is set, no request is raised, but the count keeps running.
- R8: A request is a single-cycle high on irqValid, and irqVector carries the entry's vector on that cycle.
- R9: After reset the starting count is 0, the divide setting is 0, the count is 0 and the timer entry reads 0x0001_0000 (masked, one-shot, vector 0).
- R10: Rewriting the timer entry does not change the running count or the divide phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register picked by wrSel |
| wrSel | input | 2 | Write select: 0 starting count, 1 divide, 2 timer entry |
| wrData | input | 32 | Write data |
| rdSel | input | 2 | Read select: 0 starting count, 1 divide, 2 timer entry, 3 present count |
| rdData | output | 32 | Read data for rdSel |
| irqValid | output | 1 | One-cycle interrupt request |
| irqVector | output | 8 | Vector sent with the request |

## Verification
The hardest case to reach from the ports is a timer entry rewritten in the middle of a countdown. The check must show that the count and the prescale phase carry on untouched, so the bench unmasks a masked countdown part way through and expects the request at the cycle set by the original starting-count write. A second hard case is a restart in flight: the bench writes the starting count again part way through and measures the interval from the second write. The long divide settings need many idle clocks per tick. A table of divide and count pairs makes each expected interval an exact cycle count, and one row writes a value with bit 2 set to show that the bit is dropped.

// File: rtl/interval_timer_pkg.sv
package interval_timer_pkg;
  localparam int SHIFT_W = 3;
  localparam int PRE_W = (1 << SHIFT_W) - 1;
  localparam logic [3:0] DIV_KEEP = 4'hB;
  localparam int ENTRY_PER_BIT = 17;
  localparam int ENTRY_MASK_BIT = 16;

  typedef enum logic [1:0] {
    SEL_INIT  = 2'd0,
    SEL_DIV   = 2'd1,
    SEL_ENTRY = 2'd2,
    SEL_COUNT = 2'd3
  } regSel_e;

  typedef struct packed {
    logic load;
    logic reload;
    logic dec;
  } cntStrobe_t;
endpackage

// File: rtl/interval_timer_ctrl.sv
module interval_timer_ctrl
  import interval_timer_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [3:0]       divIn,
  input  logic             perIn,
  input  logic             maskIn,
  input  logic [VEC_W-1:0] vecIn,
  input  logic             cntZero,
  input  logic             cntOne,
  output cntStrobe_t       strobe,
  output logic [3:0]       divQ,
  output logic             perQ,
  output logic             maskQ,
  output logic [VEC_W-1:0] vecQ,
  output logic             irqValid,
  output logic [VEC_W-1:0] irqVector
);
  logic [PRE_W-1:0]   preCnt;
  logic [PRE_W-1:0]   lowMask;
  logic [SHIFT_W-1:0] divCode;
  logic [SHIFT_W-1:0] shiftAmt;
  logic               tick;
  logic               initWr;
  logic               fire;

  // The prescale code is spread over bits 3, 1 and 0; the shift wraps modulo 8.
  assign divCode  = {divQ[3], divQ[1:0]};
  assign shiftAmt = divCode + SHIFT_W'(1);

  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign lowMask[i] = (SHIFT_W'(i) < shiftAmt);
  end

  assign tick   = &(preCnt | ~lowMask);
  assign initWr = wrEn && (wrSel == SEL_INIT);

  always_comb begin
    strobe.load   = initWr;
    strobe.reload = !initWr && tick && perQ && cntZero;
    strobe.dec    = !initWr && tick && !cntZero;
    fire          = !initWr && tick && !maskQ && (perQ ? cntZero : cntOne);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ      <= '0;
      perQ      <= 1'b0;
      maskQ     <= 1'b1;
      vecQ      <= '0;
      preCnt    <= '0;
      irqValid  <= 1'b0;
      irqVector <= '0;
    end else begin
      if (wrEn && (wrSel == SEL_DIV)) begin
        divQ <= divIn & DIV_KEEP;
      end
      if (wrEn && (wrSel == SEL_ENTRY)) begin
        perQ  <= perIn;
        maskQ <= maskIn;
        vecQ  <= vecIn;
      end
      if (initWr) begin
        preCnt <= '0;
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
      irqValid <= fire;
      if (fire) begin
        irqVector <= vecQ;
      end
    end
  end
endmodule

// File: rtl/interval_timer_dp.sv
module interval_timer_dp
  import interval_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [1:0]       rdSel,
  input  logic [3:0]       divQ,
  input  logic             perQ,
  input  logic             maskQ,
  input  logic [VEC_W-1:0] vecQ,
  output logic [CNT_W-1:0] initQ,
  output logic [CNT_W-1:0] cntQ,
  output logic             cntZero,
  output logic             cntOne,
  output logic [CNT_W-1:0] rdData
);
  logic [CNT_W-1:0] entryView;

  assign cntZero = (cntQ == '0);
  assign cntOne  = (cntQ == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initQ <= '0;
      cntQ  <= '0;
    end else begin
      if (strobe.load) begin
        initQ <= loadVal;
        cntQ  <= loadVal;
      end else if (strobe.reload) begin
        cntQ <= initQ;
      end else if (strobe.dec) begin
        cntQ <= cntQ - CNT_W'(1);
      end
    end
  end

  always_comb begin
    entryView                 = '0;
    entryView[ENTRY_PER_BIT]  = perQ;
    entryView[ENTRY_MASK_BIT] = maskQ;
    entryView[VEC_W-1:0]      = vecQ;
    case (regSel_e'(rdSel))
      SEL_INIT:  rdData = initQ;
      SEL_DIV:   rdData = {{(CNT_W-4){1'b0}}, divQ};
      SEL_ENTRY: rdData = entryView;
      default:   rdData = cntQ;
    endcase
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import interval_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdSel,
  output logic [CNT_W-1:0] rdData,
  output logic             irqValid,
  output logic [VEC_W-1:0] irqVector
);
  cntStrobe_t       strobe;
  logic [3:0]       divQ;
  logic             perQ;
  logic             maskQ;
  logic [VEC_W-1:0] vecQ;
  logic [CNT_W-1:0] initQ;
  logic [CNT_W-1:0] cntQ;
  logic             cntZero;
  logic             cntOne;

  interval_timer_ctrl #(.VEC_W(VEC_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .divIn(wrData[3:0]), .perIn(wrData[ENTRY_PER_BIT]),
    .maskIn(wrData[ENTRY_MASK_BIT]), .vecIn(wrData[VEC_W-1:0]),
    .cntZero(cntZero), .cntOne(cntOne), .strobe(strobe),
    .divQ(divQ), .perQ(perQ), .maskQ(maskQ), .vecQ(vecQ),
    .irqValid(irqValid), .irqVector(irqVector)
  );

  interval_timer_dp #(.CNT_W(CNT_W), .VEC_W(VEC_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadVal(wrData),
    .rdSel(rdSel), .divQ(divQ), .perQ(perQ), .maskQ(maskQ), .vecQ(vecQ),
    .initQ(initQ), .cntQ(cntQ), .cntZero(cntZero), .cntOne(cntOne),
    .rdData(rdData)
  );
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       wrSel,
  input logic [CNT_W-1:0] wrData,
  input logic             irqValid,
  input logic [CNT_W-1:0] cntQ,
  input logic [CNT_W-1:0] initQ,
  input logic             perQ,
  input logic             maskQ
);
  logic initWr;
  assign initWr = wrEn && (wrSel == 2'd0);

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    $past(initWr) |-> cntQ == $past(wrData)); // R4

  AST_ONESHOT_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && !$past(perQ)) |-> cntQ == '0); // R5

  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cntQ) == '0 && !$past(perQ) && !$past(initWr)) |-> cntQ == '0); // R5

  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && $past(perQ)) |-> cntQ == initQ); // R6

  AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> !$past(maskQ)); // R7

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(initWr) && cntQ != $past(cntQ)) |-> (cntQ == $past(cntQ) - 1 || cntQ == initQ)); // R2
endmodule

bind interval_timer interval_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .irqValid(irqValid), .cntQ(cntQ), .initQ(initQ), .perQ(perQ), .maskQ(maskQ)
);

// File: tb/test_interval_timer.sv
module test_interval_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 8;
  // Row fields: [31:28] divide write, [24] periodic, [23:12] start count, [11:0] expected edges
  localparam logic [31:0] TABLE [NROWS] = '{
    {4'hB, 3'd0, 1'b0, 12'd5, 12'd5},
    {4'h0, 3'd0, 1'b0, 12'd3, 12'd6},
    {4'h3, 3'd0, 1'b0, 12'd2, 12'd32},
    {4'h8, 3'd0, 1'b0, 12'd1, 12'd32},
    {4'hF, 3'd0, 1'b0, 12'd4, 12'd4},
    {4'h4, 3'd0, 1'b0, 12'd3, 12'd6},
    {4'hB, 3'd0, 1'b1, 12'd3, 12'd4},
    {4'h0, 3'd0, 1'b1, 12'd2, 12'd6}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdSel = 2'd0;
  logic [31:0] rdData;
  logic        irqValid;
  logic [7:0]  irqVector;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  interval_timer i_interval_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .irqValid(irqValid), .irqVector(irqVector)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [31:0] val);
    rdSel = sel; #1;
    val = rdData;
  endtask

  task automatic waitIrq(input int lim, output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!irqValid && n < lim);
  endtask

  function automatic logic [31:0] entryWord(input bit per, input bit msk, input logic [7:0] vec);
    return {14'd0, per, msk, 8'd0, vec};
  endfunction

  initial begin
    int n;
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    readReg(2'd0, v); chk("R9 start count", v, 32'h0);
    readReg(2'd1, v); chk("R9 divide", v, 32'h0);
    readReg(2'd2, v); chk("R9 entry", v, 32'h0001_0000);
    readReg(2'd3, v); chk("R9 count", v, 32'h0);
    chk("R9 irqValid", {31'd0, irqValid}, 32'h0);
    rstN = 1'b1;
    @(posedge clk); #1;

    // Table: R1 R2 R3 R5 R6 R8
    for (int i = 0; i < NROWS; i++) begin
      logic [3:0]  dw;
      bit          per;
      logic [31:0] sc;
      int          ex;
      dw  = TABLE[i][31:28];
      per = TABLE[i][24];
      sc  = {20'd0, TABLE[i][23:12]};
      ex  = int'(TABLE[i][11:0]);
      writeReg(2'd1, {28'd0, dw});
      readReg(2'd1, v); chk("R1 divide readback", v, {28'd0, dw & 4'hB});
      writeReg(2'd2, entryWord(per, 1'b0, 8'h20 + 8'(i)));
      readReg(2'd2, v); chk("R3 entry readback", v, entryWord(per, 1'b0, 8'h20 + 8'(i)));
      writeReg(2'd0, sc);
      waitIrq(200, n);
      chk("R2 edges to expiry", n, ex);
      chk("R8 vector", {24'd0, irqVector}, {24'd0, 8'h20 + 8'(i)});
      readReg(2'd3, v);
      if (per) chk("R6 reload value", v, sc);
      else     chk("R5 count at expiry", v, 32'h0);
      if (!per) begin
        @(posedge clk); #1;
        chk("R8 single-cycle pulse", {31'd0, irqValid}, 32'h0);
      end
    end

    // R6: second periodic interval (last row: div 0, start 2)
    waitIrq(200, n);
    chk("R6 second period", n, 6);

    // R5: one-shot holds at zero and fires once
    writeReg(2'd1, 32'hB);
    writeReg(2'd2, entryWord(1'b0, 1'b0, 8'h41));
    writeReg(2'd0, 32'd2);
    waitIrq(50, n);
    chk("R5 one-shot expiry", n, 2);
    waitIrq(30, n);
    chk("R5 no second request", {31'd0, irqValid}, 32'h0);
    readReg(2'd3, v); chk("R5 count stays zero", v, 32'h0);

    // R5: start count zero gives no request
    writeReg(2'd0, 32'd0);
    waitIrq(30, n);
    chk("R5 zero start silent", {31'd0, irqValid}, 32'h0);

    // R7: masked timer counts but stays silent
    writeReg(2'd2, entryWord(1'b0, 1'b1, 8'h42));
    writeReg(2'd0, 32'd3);
    waitIrq(30, n);
    chk("R7 masked silent", {31'd0, irqValid}, 32'h0);
    readReg(2'd3, v); chk("R7 masked still counts", v, 32'h0);

    // R4: load and step readback
    writeReg(2'd0, 32'd100);
    readReg(2'd3, v); chk("R4 count loaded", v, 32'd100);
    repeat (5) begin @(posedge clk); #1; end
    readReg(2'd3, v); chk("R4 count after five clocks", v, 32'd95);
    readReg(2'd0, v); chk("R4 start count readback", v, 32'd100);

    // R4: rewrite of the start count restarts the interval
    writeReg(2'd2, entryWord(1'b0, 1'b0, 8'h43));
    writeReg(2'd0, 32'd10);
    repeat (4) begin @(posedge clk); #1; end
    writeReg(2'd0, 32'd10);
    waitIrq(50, n);
    chk("R4 restart interval", n, 10);

    // R10: unmasking mid-count keeps the count running
    writeReg(2'd2, entryWord(1'b0, 1'b1, 8'h44));
    writeReg(2'd0, 32'd8);
    repeat (2) begin @(posedge clk); #1; end
    writeReg(2'd2, entryWord(1'b0, 1'b0, 8'h55));
    waitIrq(50, n);
    chk("R10 expiry after entry rewrite", n, 5);
    chk("R10 new vector", {24'd0, irqVector}, 32'h55);

    // R2: slowest divide (code 6 -> shift 7 -> 128 clocks per tick)
    writeReg(2'd1, 32'hA);
    writeReg(2'd0, 32'd1);
    waitIrq(400, n);
    chk("R2 divide by 128", n, 128);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule